// File: doc/BRIEF.md
# Routable Level Interrupt Aggregator

This block gathers 32 level-sensitive interrupt sources and fans them out onto up to 15 output interrupt lines. Software uses a small word-addressed register bus. It sets an enable bit per source, reads back the sampled source levels, and gives every source a 4-bit routing code. The code picks the output line the source drives, or leaves the source unconnected.

Each source level is captured by one flop stage. An output line is high for as long as at least one source routed to it is both enabled and sampled high. Nothing is latched, so when a source drops, its output drops one clock later. The register bus is a plain write strobe with address and data, plus combinational read data. No part of the block carries streamed data, so it has no valid/ready handshake.

Top module: `lir_irq_router`

## Requirements
- R1: A write with `reg_wr` high to byte offset 0x00 loads the enable register at the next clock edge. Reading offset 0x00 returns that value, and bit n enables source n.
- R2: Reading offset 0x04 returns the source levels as sampled at the last clock edge, whatever the enable register holds.
- R3: While reset is active, the enable register and every routing code are cleared, so all outputs stay low.
- R4: The routing code of source n is held in the routing register at byte offset 0x08 + 4·(3 − n/8), in bits [4·(n mod 8)+3 : 4·(n mod 8)]. Source 31 is therefore the top nibble at 0x08, and source 0 is the bottom nibble at 0x14.
- R5: Routing code 0 connects the source to no output. Code c, for c from 1 to 15, connects it to output line c − 1.
- R6: Output line k is the OR over all sources n where the enable bit is 1, the sampled level is 1 and the routing code equals k+1. It is derived combinationally from the registered state, so it follows a change at a source input after one clock edge.
- R7: Clearing an enable bit removes that source from its output while its level stays high. Setting the bit again restores the output with no new edge at the source.
- R8: Writes to offset 0x04 change no register.
- R9: Reads from offsets outside 0x00–0x14 return zero, and writes to them change no register. Address bits [1:0] are ignored.
- R10: A write to one routing register replaces only the eight codes held in it. The other three routing registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied at the clock edge |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 8 | Byte address; bits [1:0] are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| irq_out | output | 15 | Output interrupt lines |

## Verification
The hardest case to reach from the ports is an output line shared by several enabled sources, where one source falls or is disabled while another keeps the line high. Random routing codes are drawn from the full 4-bit range, so several sources often share a line. Random enable and level patterns then run while the routing registers are rewritten one at a time. A directed sequence toggles the enable bit of source 31 while its level stays high, and pins down the reversed nibble placement at both ends of the routing space.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int unsigned N_IN     = 32;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned FPR      = DATA_W / CODE_W;       // fields per routing register
  localparam int unsigned N_RT_REG = N_IN / FPR;
  localparam int unsigned N_OUT    = (1 << CODE_W) - 1;
  localparam int unsigned RT_W     = (N_RT_REG > 1) ? $clog2(N_RT_REG) : 1;

  // word indices of the register map
  localparam int unsigned WIDX_MASK = 0;
  localparam int unsigned WIDX_STAT = 1;
  localparam int unsigned WIDX_RT0  = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2,
    SEL_RT   = 2'd3
  } sel_e;

  typedef logic [N_IN-1:0][CODE_W-1:0] route_t;
endpackage

// File: rtl/lir_decode.sv
module lir_decode
  import lir_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [RT_W-1:0]   rt_idx
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_lo;

  assign word      = addr[ADDR_W-1:2];
  assign unused_lo = addr[1:0];

  always_comb begin
    sel    = SEL_NONE;
    rt_idx = '0;
    if (word == WORD_W'(WIDX_MASK)) begin
      sel = SEL_MASK;
    end else if (word == WORD_W'(WIDX_STAT)) begin
      sel = SEL_STAT;
    end else if (word >= WORD_W'(WIDX_RT0) && word < WORD_W'(WIDX_RT0 + N_RT_REG)) begin
      sel    = SEL_RT;
      rt_idx = RT_W'(word - WORD_W'(WIDX_RT0));
    end
  end
endmodule

// File: rtl/lir_regs.sv
module lir_regs
  import lir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  sel_e              sel,
  input  logic [RT_W-1:0]   rt_idx,
  input  logic [N_IN-1:0]   irq_in,
  output logic [N_IN-1:0]   mask_q,
  output logic [N_IN-1:0]   stat_q,
  output route_t            route_q,
  output logic [DATA_W-1:0] rdata
);
  logic [N_RT_REG-1:0][DATA_W-1:0] rt_view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= irq_in;
      if (wr_en && sel == SEL_MASK) mask_q <= wdata[N_IN-1:0];
    end
  end

  // routing codes: reversed register order, nibble position = n mod FPR
  for (genvar n = 0; n < N_IN; n++) begin : g_code
    localparam int unsigned RIDX = N_RT_REG - 1 - n / FPR;
    localparam int unsigned FOFS = (n % FPR) * CODE_W;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q <= '0;
      end else if (wr_en && sel == SEL_RT && rt_idx == RT_W'(RIDX)) begin
        code_q <= wdata[FOFS +: CODE_W];
      end
    end

    assign route_q[n]                  = code_q;
    assign rt_view[RIDX][FOFS +: CODE_W] = code_q;
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: rdata = DATA_W'(mask_q);
      SEL_STAT: rdata = DATA_W'(stat_q);
      SEL_RT:   rdata = rt_view[rt_idx];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/lir_fanin.sv
module lir_fanin
  import lir_pkg::*;
(
  input  logic [N_IN-1:0]  mask_q,
  input  logic [N_IN-1:0]  stat_q,
  input  route_t           route_q,
  output logic [N_OUT-1:0] irq_out
);
  logic [N_IN-1:0] live;
  assign live = mask_q & stat_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_line
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int n = 0; n < N_IN; n++) begin
        hit = hit | (live[n] & (route_q[n] == CODE_W'(k + 1)));
      end
    end
    assign irq_out[k] = hit;
  end
endmodule

// File: rtl/lir_irq_router.sv
module lir_irq_router
  import lir_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_IN-1:0]   irq_in,
  output logic [N_OUT-1:0]  irq_out
);
  sel_e            sel;
  logic [RT_W-1:0] rt_idx;
  logic [N_IN-1:0] mask_q;
  logic [N_IN-1:0] stat_q;
  route_t          route_q;

  lir_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (reg_addr),
    .sel    (sel),
    .rt_idx (rt_idx)
  );

  lir_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wdata   (reg_wdata),
    .sel     (sel),
    .rt_idx  (rt_idx),
    .irq_in  (irq_in),
    .mask_q  (mask_q),
    .stat_q  (stat_q),
    .route_q (route_q),
    .rdata   (reg_rdata)
  );

  lir_fanin u_fanin (
    .mask_q  (mask_q),
    .stat_q  (stat_q),
    .route_q (route_q),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/lir_checker.sv
module lir_checker
  import lir_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [N_IN-1:0]   irq_in,
  input logic [N_OUT-1:0]  irq_out,
  input sel_e              sel,
  input logic [N_IN-1:0]   mask_q,
  input logic [N_IN-1:0]   stat_q,
  input route_t            route_q
);
  // R1: enable register loads written data at the next edge
  a_r1_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_MASK) |=> mask_q == $past(reg_wdata[N_IN-1:0]));

  // R2: status is the source level of the previous edge
  a_r2_status_sample: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_q == $past(irq_in));

  // R6/R7: with every enable clear no line is driven
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (irq_out == '0));

  // R5: with every code at zero no line is driven
  a_r5_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |-> (irq_out == '0));

  // R8: writes to status alter nothing
  a_r8_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_STAT) |=> ($stable(mask_q) && $stable(route_q)));

  // R9: writes outside the map alter nothing
  a_r9_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_NONE) |=> ($stable(mask_q) && $stable(route_q)));
endmodule

bind lir_irq_router lir_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lir_irq_router_bench.sv
`timescale 1ns/1ps
module lir_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] irq_in = '0;
  logic [14:0] irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_mask = '0;
  logic [31:0] m_stat = '0;
  logic [3:0]  m_code [32];

  always #5 clk = ~clk;

  lir_irq_router u_lir_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  function automatic logic [14:0] exp_out();
    logic [14:0] o = '0;
    for (int k = 0; k < 15; k++)
      for (int n = 0; n < 32; n++)
        if (m_mask[n] && m_stat[n] && m_code[n] == 4'(k + 1)) o[k] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    int w = int'(a[7:2]);
    logic [31:0] v = '0;
    if (w == 0) v = m_mask;
    else if (w == 1) v = m_stat;
    else if (w >= 2 && w <= 5)
      for (int j = 0; j < 8; j++) v[4*j +: 4] = m_code[(3 - (w - 2)) * 8 + j];
    return v;
  endfunction

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int w = int'(a[7:2]);
    if (w == 0) m_mask = d;
    else if (w >= 2 && w <= 5)
      for (int j = 0; j < 8; j++) m_code[(3 - (w - 2)) * 8 + j] = d[4*j +: 4];
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic [31:0] lv);
    @(negedge clk);
    reg_wr = we; reg_addr = a; reg_wdata = d; irq_in = lv;
    @(negedge clk);
    if (we) model_write(a, d);
    m_stat = lv;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, model_read(a));
  endtask

  task automatic out_chk(string tag);
    chk(tag, {17'b0, irq_out}, {17'b0, exp_out()});
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int n = 0; n < 32; n++) m_code[n] = '0;
    void'($urandom(32'h5EED_1234));
    irq_in = '1;
    repeat (3) @(negedge clk);
    // R3: reset state
    chk("R3 outputs in reset", {17'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    step(1'b0, 8'h00, '0, 32'hFFFF_FFFF);
    rd_chk(8'h00, "R3 mask after reset");
    for (int r = 0; r < 4; r++) rd_chk(8'(8 + 4 * r), "R3 routing after reset");
    chk("R3 outputs after reset", {17'b0, irq_out}, 32'h0);
    // R2: status independent of mask
    step(1'b0, 8'h00, '0, 32'h1234_5678);
    rd_chk(8'h04, "R2 status with mask clear");
    // R1: mask write and read back
    step(1'b1, 8'h00, 32'hA5A5_0F0F, 32'h0);
    rd_chk(8'h00, "R1 mask readback");
    // R4/R5: source 31 in top nibble at 0x08, code 15 -> line 14
    step(1'b1, 8'h00, 32'h8000_0001, 32'h0);
    step(1'b1, 8'h08, 32'hF000_0000, 32'h8000_0000);
    chk("R4 source31 drives line14", {17'b0, irq_out}, 32'h0000_4000);
    // R4/R5: source 0 in bottom nibble at 0x14, code 1 -> line 0
    step(1'b1, 8'h14, 32'h0000_0001, 32'h8000_0001);
    chk("R5 code1 drives line0", {17'b0, irq_out}, 32'h0000_4001);
    // R5: code 0 disconnects
    step(1'b1, 8'h14, 32'h0000_0000, 32'h8000_0001);
    chk("R5 code0 disconnected", {17'b0, irq_out}, 32'h0000_4000);
    // R7: mask off and on with level held
    step(1'b1, 8'h00, 32'h0000_0001, 32'h8000_0001);
    chk("R7 masked source silent", {17'b0, irq_out}, 32'h0);
    step(1'b1, 8'h00, 32'h8000_0001, 32'h8000_0001);
    chk("R7 unmask resumes", {17'b0, irq_out}, 32'h0000_4000);
    // R6: level drop follows after one edge
    step(1'b0, 8'h00, '0, 32'h0);
    chk("R6 level drop", {17'b0, irq_out}, 32'h0);
    // R8: status write ignored
    step(1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0);
    rd_chk(8'h00, "R8 mask after status write");
    rd_chk(8'h08, "R8 routing after status write");
    // R9: unmapped
    step(1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 8'hFC, 32'hFFFF_FFFF, 32'h0);
    rd_chk(8'h18, "R9 unmapped read zero");
    rd_chk(8'h00, "R9 mask after unmapped write");
    for (int r = 0; r < 4; r++) rd_chk(8'(8 + 4 * r), "R9 routing after unmapped write");
    // R10: one routing register rewrite leaves others
    step(1'b1, 8'h0C, 32'h1357_9BDF, 32'h0);
    for (int r = 0; r < 4; r++) rd_chk(8'(8 + 4 * r), "R10 neighbour routing intact");

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [31:0] lv;
      int sel = int'($urandom_range(0, 9));
      if (sel <= 5) a = 8'(4 * sel);
      else if (sel == 6) a = 8'h18;
      else a = {$urandom_range(0, 63) % 64 == 0 ? 6'd63 : 6'($urandom_range(0, 63)), 2'b00};
      d  = $urandom();
      lv = $urandom() & $urandom();
      step(($urandom_range(0, 3) != 0), a, d, lv);
      out_chk("R6 random output");
      rd_chk({6'($urandom_range(0, 7)), 2'b00}, "R10 random readback");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule